// File: doc/BRIEF.md
# Tile-Latch Cartridge Bank Mapper

This block sits between a cartridge's ROM and RAM arrays and two host buses. The first is an 8-bit CPU bus with 16-bit addresses. The second is a video bus that fetches pattern data with 13-bit addresses. It turns CPU addresses into program-ROM or work-RAM addresses. It turns video addresses into pattern-ROM addresses. It also collects CPU writes into its bank registers and into a nametable mirroring control.

Pattern space is split into two 4 KB halves. Each half picks one of two bank registers through its own one-bit tile latch. The video bus flips a latch when it reads certain tile addresses, so the active pattern bank can change partway through a frame without any CPU write.

A second video-side translation port, the peek port, gives debug logic the same translation with no side effects on the latches. ROM sizes are set by power-of-two parameters. Every bank number is reduced to the banks that are actually present.

Top module: `tile_latch_mapper`

## Requirements
- R1: A synchronous active-high reset does the following:
  - It clears every bank register to zero.
  - It sets the mirroring output to 0 (vertical).
  - It puts both tile latches in the FD state (value 0).
- R2: A CPU write with address bits [15:12] equal to 0xA stores data bits [3:0] as the bank of program window 0 (0x8000–0x9FFF). The program ROM address is {bank mod PRG_BANKS, cpu_addr[12:0]}.
- R3: Program windows 1, 2 and 3 (address bits [14:13] = 1, 2, 3) are fixed to banks PRG_BANKS-3, PRG_BANKS-2 and PRG_BANKS-1.
- R4: Addresses 0x6000–0x7FFF select work RAM at address cpu_addr[12:0]. The work-RAM write enable is high exactly when the CPU writes in that range.
- R5: CPU writes with address bits [15:12] equal to 0xB, 0xC, 0xD or 0xE store data bits [4:0] into pattern registers 0, 1, 2 and 3. A register is used modulo CHR_BANKS.
- R6: The pattern ROM address is {bank, vid_addr[11:0]}. The lower half (vid_addr[12]=0) uses register 0 in state FD and register 1 in state FE. The upper half uses register 2 in state FD and register 3 in state FE.
- R7: A video read of exactly 0x0FD8 sets the lower latch to FD. A video read of exactly 0x0FE8 sets it to FE. Any other address leaves the lower latch unchanged.
- R8: A video read of any address in 0x1FD8–0x1FDF sets the upper latch to FD. A read in 0x1FE8–0x1FEF sets it to FE.
- R9: A triggering read is itself translated with the latch state from before that read. The new bank applies from the next cycle on.
- R10: A CPU write with address bits [15:12] equal to 0xF sets the mirroring output to data bit 0 (0 = vertical, 1 = horizontal).
- R11: The peek port always gives the same translation that the main video port would give for the same address. Peek accesses, and video cycles without a read strobe, never change a latch.
- R12: CPU addresses 0x0000–0x5FFF raise the no-device flag, and neither ROM nor RAM is selected. In every cycle at most one of the program-ROM select and the work-RAM select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| cpu_wdata | input | 8 | CPU write data |
| prg_sel | output | 1 | Program ROM is addressed |
| prg_addr | output | PRG_AW (16) | Program ROM byte address |
| wram_sel | output | 1 | Work RAM is addressed |
| wram_we | output | 1 | Work RAM write enable |
| wram_addr | output | 13 | Work RAM byte address |
| cpu_none | output | 1 | No device at this CPU address |
| vid_addr | input | 13 | Video bus pattern address |
| vid_rd | input | 1 | Video read strobe for this cycle |
| chr_addr | output | CHR_AW (16) | Pattern ROM byte address for vid_addr |
| peek_addr | input | 13 | Side-effect-free debug translation address |
| peek_chr_addr | output | CHR_AW (16) | Pattern ROM byte address for peek_addr |
| mirror_horiz | output | 1 | Mirroring mode, 1 = horizontal |

## Verification
The assertions assume the following about the inputs:
- Every address input and strobe is a defined value at each rising edge.
- A register write or a latch trigger is one strobe on one edge. The result is observed on the next edge.

The stimulus meets these assumptions. It changes every input only on falling edges and always holds both strobes at a known 0 or 1. Random video addresses are often replaced by trigger addresses and near misses, so the latch transitions occur frequently.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

    typedef enum logic { LATCH_FD = 1'b0, LATCH_FE = 1'b1 } latch_e;
    typedef enum logic { MIRR_VERT = 1'b0, MIRR_HORZ = 1'b1 } mirror_e;
    typedef enum logic [1:0] { TGT_NONE = 2'd0, TGT_WRAM = 2'd1, TGT_PRG = 2'd2 } cpu_tgt_e;

    localparam int CHR_REGS = 4;
    localparam int CHR_REG_W = 5;
    localparam int PRG_REG_W = 4;
    localparam int WRAM_AW = 13;
    localparam int VID_AW = 13;

    typedef struct packed {
        logic [PRG_REG_W-1:0]                prg_bank;
        logic [CHR_REGS-1:0][CHR_REG_W-1:0]  chr_bank;
        mirror_e                             mirror;
    } bank_regs_t;

    typedef struct packed {
        logic   hit;
        latch_e val;
    } trig_t;

    function automatic trig_t lo_trigger(logic [VID_AW-1:0] a);
        trig_t t;
        t = '{hit: 1'b0, val: LATCH_FD};
        if (a == 13'h0FD8) t = '{hit: 1'b1, val: LATCH_FD};
        else if (a == 13'h0FE8) t = '{hit: 1'b1, val: LATCH_FE};
        return t;
    endfunction

    function automatic trig_t hi_trigger(logic [VID_AW-1:0] a);
        trig_t t;
        t = '{hit: 1'b0, val: LATCH_FD};
        if (a[12:3] == 10'h3FB) t = '{hit: 1'b1, val: LATCH_FD};
        else if (a[12:3] == 10'h3FD) t = '{hit: 1'b1, val: LATCH_FE};
        return t;
    endfunction

    function automatic cpu_tgt_e cpu_target(logic [15:0] a);
        if (a[15]) return TGT_PRG;
        if (a[15:13] == 3'b011) return TGT_WRAM;
        return TGT_NONE;
    endfunction

endpackage

// File: rtl/tlm_bank_regs.sv
module tlm_bank_regs
    import tlm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_wr,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output bank_regs_t  regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (cpu_wr) begin
            case (cpu_addr[15:12])
                4'hA: regs.prg_bank    <= cpu_wdata[PRG_REG_W-1:0];
                4'hB: regs.chr_bank[0] <= cpu_wdata[CHR_REG_W-1:0];
                4'hC: regs.chr_bank[1] <= cpu_wdata[CHR_REG_W-1:0];
                4'hD: regs.chr_bank[2] <= cpu_wdata[CHR_REG_W-1:0];
                4'hE: regs.chr_bank[3] <= cpu_wdata[CHR_REG_W-1:0];
                4'hF: regs.mirror      <= mirror_e'(cpu_wdata[0]);
                default: ;
            endcase
        end
    end

    // R2
    prg_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:12] == 4'hA) |=> (regs.prg_bank == $past(cpu_wdata[3:0])));

    // R10
    mirror_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:12] == 4'hF) |=> (regs.mirror == mirror_e'($past(cpu_wdata[0]))));

    // R5
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_wr |=> $stable(regs));

endmodule

// File: rtl/tlm_tile_latches.sv
module tlm_tile_latches
    import tlm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vid_rd,
    input  logic [VID_AW-1:0] vid_addr,
    output latch_e            lo_state,
    output latch_e            hi_state
);

    trig_t lo_t, hi_t;

    always_comb begin
        lo_t = lo_trigger(vid_addr);
        hi_t = hi_trigger(vid_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_state <= LATCH_FD;
            hi_state <= LATCH_FD;
        end else if (vid_rd) begin
            if (lo_t.hit) lo_state <= lo_t.val;
            if (hi_t.hit) hi_state <= hi_t.val;
        end
    end

    // R11
    latch_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !vid_rd |=> ($stable(lo_state) && $stable(hi_state)));

    // R7
    lo_fe_chk: assert property (@(posedge clk) disable iff (rst)
        (vid_rd && vid_addr == 13'h0FE8) |=> (lo_state == LATCH_FE));

    // R8
    hi_fd_chk: assert property (@(posedge clk) disable iff (rst)
        (vid_rd && vid_addr >= 13'h1FD8 && vid_addr <= 13'h1FDF) |=> (hi_state == LATCH_FD));

endmodule

// File: rtl/tlm_chr_xlate.sv
module tlm_chr_xlate
    import tlm_pkg::*;
#(
    parameter int CHR_BW = 4,
    localparam int CHR_AW = CHR_BW + 12
) (
    input  logic [VID_AW-1:0]                   addr,
    input  logic [CHR_REGS-1:0][CHR_REG_W-1:0]  banks,
    input  latch_e                              lo_state,
    input  latch_e                              hi_state,
    output logic [CHR_AW-1:0]                   chr_addr
);

    logic [1:0]        idx;
    logic [CHR_BW-1:0] bank;

    always_comb begin
        idx      = {addr[12], (addr[12] ? hi_state : lo_state) == LATCH_FE};
        bank     = CHR_BW'(banks[idx]);
        chr_addr = {bank, addr[11:0]};
    end

endmodule

// File: rtl/tlm_prg_xlate.sv
module tlm_prg_xlate
    import tlm_pkg::*;
#(
    parameter int PRG_BANKS = 8,
    localparam int PRG_BW = $clog2(PRG_BANKS),
    localparam int PRG_AW = PRG_BW + 13
) (
    input  logic [15:0]          cpu_addr,
    input  logic [PRG_REG_W-1:0] win0_bank,
    output cpu_tgt_e             tgt,
    output logic [PRG_AW-1:0]    prg_addr,
    output logic [WRAM_AW-1:0]   wram_addr
);

    logic [1:0]        win;
    logic [PRG_BW-1:0] bank;

    always_comb begin
        tgt  = cpu_target(cpu_addr);
        win  = cpu_addr[14:13];
        if (win == 2'd0) bank = PRG_BW'(win0_bank);
        else             bank = PRG_BW'(PRG_BANKS - 4 + int'(win));
        prg_addr  = {bank, cpu_addr[12:0]};
        wram_addr = cpu_addr[WRAM_AW-1:0];
    end

endmodule

// File: rtl/tile_latch_mapper.sv
module tile_latch_mapper
    import tlm_pkg::*;
#(
    parameter int PRG_BANKS = 8,
    parameter int CHR_BANKS = 16,
    localparam int PRG_BW = $clog2(PRG_BANKS),
    localparam int CHR_BW = $clog2(CHR_BANKS),
    localparam int PRG_AW = PRG_BW + 13,
    localparam int CHR_AW = CHR_BW + 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic              prg_sel,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              wram_sel,
    output logic              wram_we,
    output logic [12:0]       wram_addr,
    output logic              cpu_none,
    input  logic [12:0]       vid_addr,
    input  logic              vid_rd,
    output logic [CHR_AW-1:0] chr_addr,
    input  logic [12:0]       peek_addr,
    output logic [CHR_AW-1:0] peek_chr_addr,
    output logic              mirror_horiz
);

    bank_regs_t regs;
    latch_e     lo_state, hi_state;
    cpu_tgt_e   tgt;

    tlm_bank_regs u_regs (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .regs(regs)
    );

    tlm_tile_latches u_latches (
        .clk(clk), .rst(rst), .vid_rd(vid_rd), .vid_addr(vid_addr),
        .lo_state(lo_state), .hi_state(hi_state)
    );

    tlm_prg_xlate #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .cpu_addr(cpu_addr), .win0_bank(regs.prg_bank),
        .tgt(tgt), .prg_addr(prg_addr), .wram_addr(wram_addr)
    );

    logic [1:0][12:0]       xl_in;
    logic [1:0][CHR_AW-1:0] xl_out;

    assign xl_in[0] = vid_addr;
    assign xl_in[1] = peek_addr;

    for (genvar g = 0; g < 2; g++) begin : g_chr
        tlm_chr_xlate #(.CHR_BW(CHR_BW)) u_xl (
            .addr(xl_in[g]), .banks(regs.chr_bank),
            .lo_state(lo_state), .hi_state(hi_state), .chr_addr(xl_out[g])
        );
    end

    assign chr_addr      = xl_out[0];
    assign peek_chr_addr = xl_out[1];
    assign prg_sel       = (tgt == TGT_PRG);
    assign wram_sel      = (tgt == TGT_WRAM);
    assign wram_we       = wram_sel && cpu_wr;
    assign cpu_none      = (tgt == TGT_NONE);
    assign mirror_horiz  = (regs.mirror == MIRR_HORZ);

    // R12
    sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prg_sel, wram_sel}) && (cpu_none != (prg_sel || wram_sel)));

    // R4
    wram_we_chk: assert property (@(posedge clk) disable iff (rst)
        wram_we |-> (wram_sel && cpu_wr));

    // R11
    peek_match_chk: assert property (@(posedge clk) disable iff (rst)
        (peek_addr == vid_addr) |-> (peek_chr_addr == chr_addr));

endmodule

// File: tb/tile_latch_mapper_test.sv
module tile_latch_mapper_test;

    localparam int PRG_BANKS = 8;
    localparam int CHR_BANKS = 16;
    localparam int PRG_AW = 16;
    localparam int CHR_AW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [12:0] vid_addr = '0, peek_addr = '0;
    logic vid_rd = 1'b0;
    logic prg_sel, wram_sel, wram_we, cpu_none, mirror_horiz;
    logic [PRG_AW-1:0] prg_addr;
    logic [12:0] wram_addr;
    logic [CHR_AW-1:0] chr_addr, peek_chr_addr;

    int tests = 0;
    int fails = 0;

    logic [3:0] m_prg;
    logic [4:0] m_chr [4];
    logic m_lo, m_hi, m_mir;

    always #2 clk = ~clk;

    tile_latch_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .prg_sel(prg_sel), .prg_addr(prg_addr), .wram_sel(wram_sel), .wram_we(wram_we),
        .wram_addr(wram_addr), .cpu_none(cpu_none), .vid_addr(vid_addr), .vid_rd(vid_rd),
        .chr_addr(chr_addr), .peek_addr(peek_addr), .peek_chr_addr(peek_chr_addr),
        .mirror_horiz(mirror_horiz)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [CHR_AW-1:0] exp_chr(input logic [12:0] a);
        logic [1:0] idx;
        idx = {a[12], a[12] ? m_hi : m_lo};
        return {m_chr[idx][3:0], a[11:0]};
    endfunction

    function automatic logic [PRG_AW-1:0] exp_prg(input logic [15:0] a);
        logic [2:0] b;
        if (a[14:13] == 2'd0) b = m_prg[2:0];
        else b = 3'(PRG_BANKS - 4 + int'(a[14:13]));
        return {b, a[12:0]};
    endfunction

    task automatic model_reset();
        m_prg = 0; m_lo = 0; m_hi = 0; m_mir = 0;
        for (int i = 0; i < 4; i++) m_chr[i] = 0;
    endtask

    task automatic drive(input logic [15:0] ca, input logic wr, input logic [7:0] wd,
                         input logic [12:0] va, input logic rd, input logic [12:0] pa);
        @(negedge clk);
        cpu_addr = ca; cpu_wr = wr; cpu_wdata = wd;
        vid_addr = va; vid_rd = rd; peek_addr = pa;
        #1;
    endtask

    task automatic check_all();
        logic is_prg, is_wram;
        is_prg  = cpu_addr[15];
        is_wram = cpu_addr[15:13] == 3'b011;
        check("R12 none", cpu_none, !is_prg && !is_wram);
        check("R12 prg_sel", prg_sel, is_prg);
        if (is_prg) check(cpu_addr[14:13] == 0 ? "R2 prg_addr" : "R3 prg_addr", prg_addr, exp_prg(cpu_addr));
        check("R4 wram_sel", wram_sel, is_wram);
        check("R4 wram_we", wram_we, is_wram && cpu_wr);
        if (is_wram) check("R4 wram_addr", wram_addr, cpu_addr[12:0]);
        check("R6 chr_addr", chr_addr, exp_chr(vid_addr));
        check("R11 peek", peek_chr_addr, exp_chr(peek_addr));
        check("R10 mirror", mirror_horiz, m_mir);
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) model_reset();
        else begin
            if (cpu_wr) begin
                case (cpu_addr[15:12])
                    4'hA: m_prg = cpu_wdata[3:0];
                    4'hB: m_chr[0] = cpu_wdata[4:0];
                    4'hC: m_chr[1] = cpu_wdata[4:0];
                    4'hD: m_chr[2] = cpu_wdata[4:0];
                    4'hE: m_chr[3] = cpu_wdata[4:0];
                    4'hF: m_mir = cpu_wdata[0];
                    default: ;
                endcase
            end
            if (vid_rd) begin
                if (vid_addr == 13'h0FD8) m_lo = 0;
                else if (vid_addr == 13'h0FE8) m_lo = 1;
                if (vid_addr[12:3] == 10'h3FB) m_hi = 0;
                else if (vid_addr[12:3] == 10'h3FD) m_hi = 1;
            end
        end
    endtask

    task automatic step(input logic [15:0] ca, input logic wr, input logic [7:0] wd,
                        input logic [12:0] va, input logic rd, input logic [12:0] pa);
        drive(ca, wr, wd, va, rd, pa);
        check_all();
        tick();
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        rst = 1'b1;
        drive(16'h0000, 1'b1, 8'hFF, 13'h1456, 1'b1, 13'h0123);
        tick();
        tick();
        rst = 1'b0;
        // R1: reset state
        drive(16'h0000, 1'b0, 8'h00, 13'h1456, 1'b0, 13'h0123);
        check("R1 chr hi", chr_addr, 16'h0456);
        check("R1 chr lo", peek_chr_addr, 16'h0123);
        check("R1 mirror", mirror_horiz, 1'b0);
        tick();

        // R5: register loads, bit 4 masked by 16 banks
        step(16'hB123, 1'b1, 8'hE3, 13'h0000, 1'b0, 13'h0000);
        step(16'hCFFF, 1'b1, 8'h1F, 13'h0000, 1'b0, 13'h0000);
        step(16'hD000, 1'b1, 8'h07, 13'h0000, 1'b0, 13'h0000);
        step(16'hE800, 1'b1, 8'h29, 13'h0000, 1'b0, 13'h0000);
        drive(16'h0000, 1'b0, 8'h00, 13'h0100, 1'b1, 13'h1200);
        check("R5 reg0", chr_addr, 16'h3100);
        check("R6 hi fd", peek_chr_addr, 16'h7200);
        tick();
        // R9: trigger read uses old latch state
        drive(16'h0000, 1'b0, 8'h00, 13'h0FE8, 1'b1, 13'h0FE8);
        check("R9 old state", chr_addr, 16'h3FE8);
        tick();
        drive(16'h0000, 1'b0, 8'h00, 13'h0100, 1'b1, 13'h0100);
        check("R7 lo fe", chr_addr, 16'hF100);
        tick();
        // R7: near misses leave the lower latch alone
        step(16'h0000, 1'b0, 8'h00, 13'h0FD9, 1'b1, 13'h0000);
        step(16'h0000, 1'b0, 8'h00, 13'h0FD0, 1'b1, 13'h0000);
        drive(16'h0000, 1'b0, 8'h00, 13'h0100, 1'b1, 13'h0100);
        check("R7 near miss", chr_addr, 16'hF100);
        tick();
        // R8: upper range triggers
        step(16'h0000, 1'b0, 8'h00, 13'h1FEC, 1'b1, 13'h0000);
        drive(16'h0000, 1'b0, 8'h00, 13'h1200, 1'b0, 13'h1200);
        check("R8 hi fe", chr_addr, 16'h9200);
        tick();
        step(16'h0000, 1'b0, 8'h00, 13'h1FF0, 1'b1, 13'h0000);
        drive(16'h0000, 1'b0, 8'h00, 13'h1200, 1'b0, 13'h1200);
        check("R8 outside range", chr_addr, 16'h9200);
        tick();
        step(16'h0000, 1'b0, 8'h00, 13'h1FDF, 1'b1, 13'h0000);
        drive(16'h0000, 1'b0, 8'h00, 13'h1200, 1'b0, 13'h1200);
        check("R8 hi fd", chr_addr, 16'h7200);
        tick();
        // R11: peek of a trigger and an unstrobed trigger change nothing
        step(16'h0000, 1'b0, 8'h00, 13'h0FD8, 1'b0, 13'h0FD8);
        drive(16'h0000, 1'b0, 8'h00, 13'h0100, 1'b0, 13'h0FD8);
        check("R11 no side effect", chr_addr, 16'hF100);
        tick();
        // R2 / R3: program windows
        step(16'hA000, 1'b1, 8'hFD, 13'h0000, 1'b0, 13'h0000);
        drive(16'h8123, 1'b0, 8'h00, 13'h0000, 1'b0, 13'h0000);
        check("R2 win0 masked", prg_addr, 16'hA123);
        tick();
        drive(16'hFFFF, 1'b0, 8'h00, 13'h0000, 1'b0, 13'h0000);
        check("R3 last bank", prg_addr, 16'hFFFF);
        tick();
        drive(16'hA000, 1'b0, 8'h00, 13'h0000, 1'b0, 13'h0000);
        check("R3 third last", prg_addr, 16'hA000);
        tick();
        // R10 / R4 / R12 directed
        step(16'hF000, 1'b1, 8'h01, 13'h0000, 1'b0, 13'h0000);
        step(16'h7ABC, 1'b1, 8'h55, 13'h0000, 1'b0, 13'h0000);
        step(16'h5FFF, 1'b1, 8'h55, 13'h0000, 1'b0, 13'h0000);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] ca;
            logic [12:0] va, pa;
            logic [3:0] k;
            ca = 16'($urandom);
            k = 4'($urandom_range(0, 7));
            case (k)
                0: va = 13'h0FD8;
                1: va = 13'h0FE8;
                2: va = 13'h1FD8 | 13'($urandom_range(0, 7));
                3: va = 13'h1FE8 | 13'($urandom_range(0, 7));
                4: va = 13'h1FE0 | 13'($urandom_range(0, 31));
                default: va = 13'($urandom);
            endcase
            pa = ($urandom_range(0, 3) == 0) ? va : 13'($urandom);
            step(ca, $urandom_range(0, 2) == 0, 8'($urandom), va, $urandom_range(0, 3) != 0, pa);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule